// File: doc/BRIEF.md
# Pipelined Approximate Multiply-Accumulate Unit

This block multiplies two unsigned 8-bit operands on every cycle and keeps a 16-bit running result. Each operation either writes the fresh product into the accumulator and drops the old value, or adds the product to the old value. The work is split over three register stages: operand capture, product, and accumulator update. A new operation can enter on every cycle, and nothing stalls. The accumulator is updated in the last stage and reads its own value back, so each operation sees the result of the one just before it.

A mode input selects the adder used for accumulation. The exact adder is a plain 16-bit sum. The approximate adder forms each of the four lowest result bits as the NAND of the matching bits of the two addends, and it adds the upper twelve bits with no carry coming in from below. This removes the low part of the carry chain. It suits filters and similar workloads that can accept a small error in the low bits. The mode is sampled together with the operands, so mixed traffic is allowed.

A synchronous clear zeroes the accumulator and cancels every operation in flight.

Top module: `lowpart_mac`

## Requirements
- R1: While the active-low reset is held, `accOut` reads 0 and `outValid` reads 0.
- R2: An operation sampled with `inValid` high and `clear` low makes `outValid` high for exactly one cycle, three cycles later. `outValid` is never high otherwise.
- R3: With `inOp` = 0 (plain multiply), the operation writes `opA*opB` into the accumulator and ignores the old value.
- R4: With `inOp` = 1 and `approxMode` = 0, the operation writes the old accumulator plus `opA*opB`, wrapped modulo 2^16, with no overflow indication.
- R5: With `inOp` = 1 and `approxMode` = 1, result bits [3:0] are the bitwise NAND of bits [3:0] of the old accumulator and of the product. Result bits [15:4] are the sum of bits [15:4] of the two addends modulo 2^12, with no carry from bits [3:0].
- R6: Operations issued on consecutive cycles each accumulate onto the result of the operation immediately before them, with no stall cycles.
- R7: `clear` high at a clock edge makes `accOut` 0 and `outValid` 0 after that edge. Operations sampled at that edge, or still in the pipeline, produce no output beat.
- R8: The accumulator holds its value on every cycle in which no operation completes and no clear occurs.
- R9: `inOp` and `approxMode` are sampled in the same cycle as the operands. Changing `approxMode` while an operation is in flight does not change that operation's result.
- R10: `approxMode` has no effect on a plain multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and operation are presented this cycle |
| inOp | input | 1 | 0 = plain multiply, 1 = multiply-accumulate |
| approxMode | input | 1 | 1 = use the approximate low-part adder for accumulation |
| clear | input | 1 | Synchronous clear of the accumulator and the pipeline |
| opA | input | 8 | Unsigned multiplicand |
| opB | input | 8 | Unsigned multiplier |
| accOut | output | 16 | Accumulator value |
| outValid | output | 1 | An operation completed at the last edge |

## Verification
Fixed-seed random streams mix plain multiplies with exact and approximate accumulates, idle bubbles and rare clears. Because the mode and the operation change on every beat, a result taken from the wrong pipeline slot or through the wrong adder gives a different value.

Directed cases cover the following:
- full-scale operands that force a 16-bit wrap, which separates modulo arithmetic from saturation;
- an approximate add whose low nibbles would carry in exact arithmetic, which exposes any carry leaking into bit 4;
- an unbroken run of accumulates, which shows the feedback path uses the newest sum;
- a mode flip just after issue, which shows the mode is captured with its operands;
- clears that arrive together with, and behind, live operations.

// File: rtl/lowpart_mac_pkg.sv
package lowpart_mac_pkg;

  // Strobes from the control path to the datapath.
  typedef struct packed {
    logic s1Load;    // capture operands into stage 1
    logic s2Load;    // capture product into stage 2
    logic s3Write;   // stage 3 updates the accumulator
    logic s3Acc;     // stage 3 adds onto the old value (else loads)
    logic s3Approx;  // stage 3 uses the low-part approximate adder
    logic flush;     // zero the accumulator
  } macStrobes_t;

endpackage

// File: rtl/lowpart_adder.sv
module lowpart_adder #(
  parameter int W   = 16,
  parameter int LOW = 4
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  input  logic         approx,
  output logic [W-1:0] sum
);

  logic [W-1:0] exactSum;
  logic [W-1:0] approxSum;

  assign exactSum = addA + addB;

  generate
    if (LOW > 0) begin : g_lowpart
      logic [LOW-1:0] lowBits;
      logic [W-LOW-1:0] highBits;
      for (genvar i = 0; i < LOW; i++) begin : g_nand
        assign lowBits[i] = ~(addA[i] & addB[i]);
      end
      // upper field adds with no carry entering from the low part
      assign highBits  = addA[W-1:LOW] + addB[W-1:LOW];
      assign approxSum = {highBits, lowBits};
    end else begin : g_exact_only
      assign approxSum = exactSum;
    end
  endgenerate

  assign sum = approx ? approxSum : exactSum;

endmodule

// File: rtl/lowpart_mac_ctrl.sv
module lowpart_mac_ctrl
  import lowpart_mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inOp,
  input  logic        approxMode,
  input  logic        clear,
  output macStrobes_t ctl,
  output logic        outValid
);

  logic v1, v2, v3;
  logic op1, op2;
  logic md1, md2;

  always_comb begin
    ctl.s1Load   = inValid & ~clear;
    ctl.s2Load   = v1 & ~clear;
    ctl.s3Write  = v2 & ~clear;
    ctl.s3Acc    = op2;
    ctl.s3Approx = md2;
    ctl.flush    = clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1  <= 1'b0;
      v2  <= 1'b0;
      v3  <= 1'b0;
      op1 <= 1'b0;
      op2 <= 1'b0;
      md1 <= 1'b0;
      md2 <= 1'b0;
    end else begin
      v1 <= ctl.s1Load;
      v2 <= v1 & ~clear;
      v3 <= v2 & ~clear;
      if (ctl.s1Load) begin
        op1 <= inOp;
        md1 <= approxMode;
      end
      if (v1) begin
        op2 <= op1;
        md2 <= md1;
      end
    end
  end

  assign outValid = v3;

endmodule

// File: rtl/lowpart_mac_dp.sv
module lowpart_mac_dp
  import lowpart_mac_pkg::*;
#(
  parameter int OPW     = 8,
  parameter int ACCW    = 16,
  parameter int LOWBITS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  macStrobes_t     ctl,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  output logic [ACCW-1:0] accOut
);

  localparam int PRODW = 2 * OPW;

  logic [OPW-1:0]   opAR, opBR;
  logic [PRODW-1:0] prodR;
  logic [ACCW-1:0]  accR;
  logic [ACCW-1:0]  prodExt;
  logic [ACCW-1:0]  sumW;

  assign prodExt = ACCW'(prodR);

  lowpart_adder #(.W(ACCW), .LOW(LOWBITS)) addI (
    .addA  (accR),
    .addB  (prodExt),
    .approx(ctl.s3Approx),
    .sum   (sumW)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAR  <= '0;
      opBR  <= '0;
      prodR <= '0;
      accR  <= '0;
    end else begin
      if (ctl.s1Load) begin
        opAR <= opA;
        opBR <= opB;
      end
      if (ctl.s2Load) begin
        prodR <= PRODW'(opAR) * PRODW'(opBR);
      end
      if (ctl.flush) begin
        accR <= '0;
      end else if (ctl.s3Write) begin
        accR <= ctl.s3Acc ? sumW : prodExt;
      end
    end
  end

  assign accOut = accR;

endmodule

// File: rtl/lowpart_mac.sv
module lowpart_mac
  import lowpart_mac_pkg::*;
#(
  parameter int OPW     = 8,
  parameter int ACCW    = 16,
  parameter int LOWBITS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inOp,
  input  logic            approxMode,
  input  logic            clear,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  output logic [ACCW-1:0] accOut,
  output logic            outValid
);

  macStrobes_t ctl;

  lowpart_mac_ctrl ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inOp      (inOp),
    .approxMode(approxMode),
    .clear     (clear),
    .ctl       (ctl),
    .outValid  (outValid)
  );

  lowpart_mac_dp #(.OPW(OPW), .ACCW(ACCW), .LOWBITS(LOWBITS)) dpI (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .opA   (opA),
    .opB   (opB),
    .accOut(accOut)
  );

endmodule

// File: rtl/lowpart_mac_checker.sv
module lowpart_mac_checker #(
  parameter int OPW     = 8,
  parameter int ACCW    = 16,
  parameter int LOWBITS = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            inOp,
  input logic            approxMode,
  input logic            clear,
  input logic [OPW-1:0]  opA,
  input logic [OPW-1:0]  opB,
  input logic [ACCW-1:0] accOut,
  input logic            outValid
);

  // input history, three deep, and the previous accumulator value
  logic [OPW-1:0]  hA1, hA2, hA3, hB1, hB2, hB3;
  logic            hOp1, hOp2, hOp3, hMd1, hMd2, hMd3;
  logic            ok1, ok2, ok3, clrD1;
  logic [ACCW-1:0] prevAcc;
  logic [1:0]      since;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {hA1, hA2, hA3, hB1, hB2, hB3} <= '0;
      {hOp1, hOp2, hOp3, hMd1, hMd2, hMd3} <= '0;
      {ok1, ok2, ok3, clrD1} <= '0;
      prevAcc <= '0;
      since   <= '0;
    end else begin
      hA1 <= opA;  hA2 <= hA1;  hA3 <= hA2;
      hB1 <= opB;  hB2 <= hB1;  hB3 <= hB2;
      hOp1 <= inOp;       hOp2 <= hOp1; hOp3 <= hOp2;
      hMd1 <= approxMode; hMd2 <= hMd1; hMd3 <= hMd2;
      ok1 <= inValid & ~clear;
      ok2 <= ok1 & ~clear;
      ok3 <= ok2 & ~clear;
      clrD1   <= clear;
      prevAcc <= accOut;
      if (since != 2'd3) since <= since + 2'd1;
    end
  end

  logic [ACCW-1:0]         prodX;
  logic [ACCW-1:0]         exactX;
  logic [LOWBITS-1:0]      lowX;
  logic [ACCW-LOWBITS-1:0] highX;

  assign prodX  = ACCW'(hA3) * ACCW'(hB3);
  assign exactX = prevAcc + prodX;
  assign lowX   = ~(prevAcc[LOWBITS-1:0] & prodX[LOWBITS-1:0]);
  assign highX  = prevAcc[ACCW-1:LOWBITS] + prodX[ACCW-1:LOWBITS];

  always_comb begin
    if (!rstN) begin
      AST_RESET_STATE: assert (accOut == '0 && !outValid); // R1
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == ok3); // R2

  AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !hOp3) |-> accOut == prodX); // R3

  AST_EXACT_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && hOp3 && !hMd3) |-> accOut == exactX); // R4

  AST_APPROX_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && hOp3 && hMd3) |-> (accOut[LOWBITS-1:0] == lowX && accOut[ACCW-1:LOWBITS] == highX)); // R5

  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (accOut == '0 && !outValid)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (since >= 2'd2 && !outValid && !clrD1) |-> accOut == prevAcc); // R8

endmodule

bind lowpart_mac lowpart_mac_checker #(.OPW(OPW), .ACCW(ACCW), .LOWBITS(LOWBITS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inOp      (inOp),
  .approxMode(approxMode),
  .clear     (clear),
  .opA       (opA),
  .opB       (opB),
  .accOut    (accOut),
  .outValid  (outValid)
);

// File: tb/lowpart_mac_tb_top.sv
module lowpart_mac_tb_top;

  logic        clk = 1'b0;
  logic        rstN, inValid, inOp, approxMode, clear;
  logic [7:0]  opA, opB;
  logic [15:0] accOut;
  logic        outValid;

  always #5 clk = ~clk;

  lowpart_mac dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
    .approxMode(approxMode), .clear(clear), .opA(opA), .opB(opB),
    .accOut(accOut), .outValid(outValid)
  );

  int nChk = 0;
  int nFail = 0;

  logic [15:0] modelAcc, expAcc;
  logic        expValid;
  logic        pV [1:3];
  logic [15:0] pD [1:3];
  string       pTag [1:3];
  string       accTag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // R5 reference: NAND low nibble, carry-free upper field
  function automatic logic [15:0] refApprox(input logic [15:0] x, input logic [15:0] y);
    logic [11:0] up;
    up = x[15:4] + y[15:4];
    return {up, ~(x[3:0] & y[3:0])};
  endfunction

  task automatic step(input logic v, input logic op, input logic md, input logic clr,
                      input logic [7:0] a, input logic [7:0] b, input string tagIn);
    logic [15:0] prod, res;
    string tag;
    inValid = v; inOp = op; approxMode = md; clear = clr; opA = a; opB = b;
    tag = tagIn;
    if (tag == "") tag = !op ? (md ? "R10" : "R3") : (md ? "R5" : "R4");
    @(posedge clk);
    if (clr) begin
      for (int i = 1; i <= 3; i++) pV[i] = 1'b0;
      modelAcc = 16'h0; expAcc = 16'h0; expValid = 1'b0; accTag = "R7";
    end else begin
      prod = {8'h0, a} * {8'h0, b};
      res  = !op ? prod : (md ? refApprox(modelAcc, prod) : modelAcc + prod);
      pV[3] = pV[2]; pD[3] = pD[2]; pTag[3] = pTag[2];
      pV[2] = pV[1]; pD[2] = pD[1]; pTag[2] = pTag[1];
      pV[1] = v;     pD[1] = res;   pTag[1] = tag;
      if (v) modelAcc = res;
      expValid = pV[3];
      if (pV[3]) begin expAcc = pD[3]; accTag = pTag[3]; end
      else accTag = "R8";
    end
    @(negedge clk);
    chk(outValid === expValid, clr ? "R7" : "R2", {31'h0, outValid}, {31'h0, expValid});
    chk(accOut === expAcc, accTag, {16'h0, accOut}, {16'h0, expAcc});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, "");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL R2: watchdog expired, actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int seed;
    logic [31:0] r;
    seed = 32'h5eed_0042;
    r = $urandom(seed);
    rstN = 1'b0; inValid = 1'b0; inOp = 1'b0; approxMode = 1'b0; clear = 1'b0;
    opA = 8'h0; opB = 8'h0;
    modelAcc = 16'h0; expAcc = 16'h0; expValid = 1'b0; accTag = "R8";
    for (int i = 1; i <= 3; i++) begin pV[i] = 1'b0; pD[i] = 16'h0; pTag[i] = ""; end
    repeat (3) begin
      @(negedge clk);
      chk(accOut === 16'h0, "R1", {16'h0, accOut}, 32'h0);
      chk(outValid === 1'b0, "R1", {31'h0, outValid}, 32'h0);
    end
    rstN = 1'b1;

    // R3: plain multiply, then bubbles that must hold (R8)
    step(1, 0, 0, 0, 8'd3, 8'd5, "R3");
    idle(4);
    // R4: full-scale accumulates, second one wraps modulo 2^16
    step(1, 1, 0, 0, 8'd255, 8'd255, "R4");
    step(1, 1, 0, 0, 8'd255, 8'd255, "R4");
    idle(4);
    // R10: mode set on a plain multiply has no effect
    step(1, 0, 1, 0, 8'd16, 8'd16, "R10");
    idle(3);
    // R5: low nibble 0xF plus 0x1 would carry; approximate gives 0x000E
    step(1, 0, 0, 0, 8'd3, 8'd5, "R3");
    step(1, 1, 1, 0, 8'd1, 8'd1, "R5");
    step(1, 1, 1, 0, 8'd17, 8'd31, "R5");
    idle(4);
    // R6: unbroken run of accumulates
    step(1, 0, 0, 0, 8'd7, 8'd9, "R6");
    for (int i = 1; i <= 5; i++) step(1, 1, 0, 0, 8'(i * 37), 8'(i + 2), "R6");
    idle(4);
    // R9: mode flips right after issue; the in-flight op keeps its mode
    step(1, 1, 1, 0, 8'd45, 8'd77, "R9");
    step(0, 0, 0, 0, 8'd0, 8'd0, "R9");
    step(0, 0, 0, 0, 8'd0, 8'd0, "R9");
    step(1, 1, 0, 0, 8'd45, 8'd77, "R9");
    step(0, 0, 1, 0, 8'd0, 8'd0, "R9");
    idle(3);
    // R7: clear behind live operations and together with a new one
    step(1, 0, 0, 0, 8'd200, 8'd3, "R7");
    step(1, 1, 0, 0, 8'd100, 8'd3, "R7");
    step(1, 1, 0, 1, 8'd50, 8'd50, "R7");
    idle(4);
    step(1, 1, 0, 0, 8'd2, 8'd3, "R7");
    step(0, 0, 0, 1, 8'd0, 8'd0, "R7");
    idle(4);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic v, op, md, clr;
      r   = $urandom;
      v   = (r[1:0] != 2'b00);
      op  = r[2] | r[3];
      md  = r[4];
      clr = (r[11:5] < 7'd3);
      step(v, op, md, clr, r[19:12], r[27:20], "");
    end
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule